// File: doc/BRIEF.md
# Frame-Synchronous Line Scrambler with BIP-8 Section Parity

This block sits between a byte-wide terminal interface and a line interface of a synchronous optical framer. In the transmit direction it takes framed bytes, writes the section parity byte into its slot, and scrambles every byte outside the framing and trace region with a frame-synchronous keystream. In the receive direction it descrambles the line bytes, accumulates bit-interleaved parity over the received (still scrambled) bytes, and compares that parity with the descrambled parity byte of the next frame.

Each direction has its own frame marker input. The marker is high on the last framing byte of a frame (the final A2 byte), so the byte after it is position 0 of the next frame. Frame search and serial conversion are done elsewhere. One enable input turns all processing on or off for both directions at once. Receive parity mismatches come out as a train of one-cycle pulses, one pulse per mismatched bit.

Top module: `fsync_scrambler_b1`

## Requirements
- R1: Until the first marker of a direction has been seen, that direction's output equals its input, and no error pulse is raised.
- R2: After reset both data outputs and the error output are zero. Each data output shows the processed input byte exactly one clock after that byte is presented.
- R3: The marker byte, the FRAMING_BYTES-1 bytes before it (positions FRAME_BYTES-FRAMING_BYTES to FRAME_BYTES-1) and the first SKIP_BYTES bytes after it (positions 0 to SKIP_BYTES-1) leave the block unchanged.
- R4: Every other transmit byte is XORed with the keystream of the generator x^7 + x^6 + 1. The generator is loaded with all ones on each marker and steps only on scrambled bytes. Bit 7 takes the first keystream bit, so the first scrambled byte of a frame is XORed with 0xFE.
- R5: At position B1_POS the transmit side replaces the input byte with the even bit-interleaved parity of all line bytes of the previous frame (the byte after the previous marker through the marker byte). It then scrambles that byte. In the first frame after the first marker it inserts 0x00.
- R6: The receive output is the line byte XORed with the same keystream at the same positions. At position B1_POS this gives the descrambled parity byte.
- R7: The receive parity is the even bit-interleaved parity of all received line bytes of a frame. It is compared with the descrambled byte at B1_POS of the following frame. No comparison is made before one full frame has been accumulated.
- R8: A comparison with k mismatched bits drives the error output high for exactly k consecutive clocks. The first of these clocks is the one in which the parity byte appears on the receive output.
- R9: While the enable is low, both directions pass data unchanged, nothing is inserted, and the error output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_en | input | 1 | 1: scramble, insert and check parity; 0: transparent |
| tx_byte_in | input | 8 | Transmit byte from the terminal side |
| tx_frame_mark | input | 1 | High on the last framing byte of a transmit frame |
| tx_line_out | output | 8 | Transmit byte toward the line |
| rx_line_in | input | 8 | Received line byte |
| rx_frame_mark | input | 1 | High on the last framing byte of a received frame |
| rx_byte_out | output | 8 | Descrambled receive byte |
| b1_err_pulse | output | 1 | One clock high per mismatched parity bit |

## Verification
The bench builds the block with a 20-byte frame, 2 framing bytes, 1 trace byte and the parity slot at position 3. With frames this short, a run can cover many hundreds of frames. The transmit output is looped back into the receive input. In each frame one payload byte is corrupted with the frame number as the bit mask, so every one of the 256 possible mismatch patterns reaches the parity check and is counted in pulses. Runs with the enable low and high again then cover bypass, and the comparison across a bypass-to-active boundary.

// File: rtl/b1s_pkg.sv
package b1s_pkg;
    localparam int BYTE_W = 8;
    localparam int KEY_W  = 7;
    localparam logic [KEY_W-1:0] KEY_SEED = '1;

    typedef enum logic {LANE_TX = 1'b0, LANE_RX = 1'b1} lane_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ks;
        logic [KEY_W-1:0]  nxt;
    } key_t;

    // Eight steps of the x^7 + x^6 + 1 generator, first bit into bit 7.
    function automatic key_t key_advance(input logic [KEY_W-1:0] s);
        key_t r;
        logic [KEY_W-1:0] st;
        st   = s;
        r.ks = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            r.ks[i] = st[KEY_W-1];
            st      = {st[KEY_W-2:0], st[KEY_W-1] ^ st[KEY_W-2]};
        end
        r.nxt = st;
        return r;
    endfunction
endpackage

// File: rtl/b1s_framer.sv
module b1s_framer
    import b1s_pkg::*;
#(
    parameter int FRAME_BYTES   = 2430,
    parameter int FRAMING_BYTES = 6,
    parameter int SKIP_BYTES    = 3,
    parameter int B1_POS        = 264,
    localparam int POS_W        = $clog2(FRAME_BYTES),
    localparam int SCR_END      = FRAME_BYTES - FRAMING_BYTES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    output logic synced,
    output logic full,
    output logic scr_pos,
    output logic b1_pos
);
    typedef struct packed {
        logic             sync;
        logic             full;
        logic [POS_W-1:0] pos;
    } fr_st_t;

    fr_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (mark) begin
            st_d.pos  = '0;
            st_d.full = st_q.sync;
            st_d.sync = 1'b1;
        end else if (st_q.sync) begin
            st_d.pos = (st_q.pos == POS_W'(FRAME_BYTES - 1)) ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign synced  = st_q.sync;
    assign full    = st_q.full;
    assign scr_pos = st_q.sync && !mark
                     && (st_q.pos >= POS_W'(SKIP_BYTES))
                     && (st_q.pos <  POS_W'(SCR_END));
    assign b1_pos  = st_q.sync && !mark && (st_q.pos == POS_W'(B1_POS));
endmodule

// File: rtl/b1s_keystream.sv
module b1s_keystream
    import b1s_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    output logic [BYTE_W-1:0] ks
);
    typedef struct packed {
        logic [KEY_W-1:0] lfsr;
    } ks_st_t;

    ks_st_t st_q, st_d;
    key_t   step;

    always_comb begin
        step = key_advance(st_q.lfsr);
        st_d = st_q;
        if (restart)      st_d.lfsr = KEY_SEED;
        else if (advance) st_d.lfsr = step.nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.lfsr <= KEY_SEED;
        else        st_q      <= st_d;
    end

    assign ks = step.ks;
endmodule

// File: rtl/b1s_bip8.sv
module b1s_bip8
    import b1s_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              frame_end,
    input  logic [BYTE_W-1:0] line,
    output logic [BYTE_W-1:0] b1
);
    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] b1;
    } bip_st_t;

    bip_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (frame_end) begin
            st_d.b1  = st_q.acc ^ line;
            st_d.acc = '0;
        end else begin
            st_d.acc = sync ? (st_q.acc ^ line) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign b1 = st_q.b1;
endmodule

// File: rtl/b1s_err_serial.sv
module b1s_err_serial
    import b1s_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic [BYTE_W-1:0] mask,
    output logic              pulse
);
    typedef struct packed {
        logic [BYTE_W-1:0] pend;
    } es_st_t;

    es_st_t            st_q, st_d;
    logic [BYTE_W-1:0] drop;
    logic              hit;

    always_comb begin
        drop = st_q.pend;
        hit  = 1'b0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (!hit && st_q.pend[i]) begin
                drop[i] = 1'b0;
                hit     = 1'b1;
            end
        end
        st_d.pend = en ? (drop | (load ? mask : '0)) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = |st_q.pend;
endmodule

// File: rtl/b1s_lane.sv
module b1s_lane
    import b1s_pkg::*;
#(
    parameter lane_e DIR        = LANE_TX,
    parameter int FRAME_BYTES   = 2430,
    parameter int FRAMING_BYTES = 6,
    parameter int SKIP_BYTES    = 3,
    parameter int B1_POS        = 264
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    input  logic              mark,
    output logic [BYTE_W-1:0] dout,
    output logic              err
);
    logic              synced, full, scr_pos, b1_pos;
    logic [BYTE_W-1:0] ks, b1, line_b, par_b;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
    } ln_st_t;

    ln_st_t st_q, st_d;

    b1s_framer #(
        .FRAME_BYTES  (FRAME_BYTES),
        .FRAMING_BYTES(FRAMING_BYTES),
        .SKIP_BYTES   (SKIP_BYTES),
        .B1_POS       (B1_POS)
    ) u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .mark   (mark),
        .synced (synced),
        .full   (full),
        .scr_pos(scr_pos),
        .b1_pos (b1_pos)
    );

    b1s_keystream u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(mark),
        .advance(scr_pos),
        .ks     (ks)
    );

    b1s_bip8 u_bip (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync     (synced),
        .frame_end(mark),
        .line     (par_b),
        .b1       (b1)
    );

    generate
        if (DIR == LANE_TX) begin : g_tx
            logic [BYTE_W-1:0] pre;
            always_comb begin
                pre    = (en && b1_pos) ? (full ? b1 : '0) : din;
                line_b = (en && scr_pos) ? (pre ^ ks) : pre;
            end
            assign par_b = line_b;
            assign err   = 1'b0;
        end else begin : g_rx
            logic [BYTE_W-1:0] miss;
            logic              load;
            always_comb begin
                line_b = (en && scr_pos) ? (din ^ ks) : din;
                miss   = line_b ^ b1;
                load   = en && b1_pos && full;
            end
            assign par_b = din;
            b1s_err_serial u_err (
                .clk  (clk),
                .rst_n(rst_n),
                .en   (en),
                .load (load),
                .mask (miss),
                .pulse(err)
            );
        end
    endgenerate

    always_comb begin
        st_d.data = line_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.data;
endmodule

// File: rtl/fsync_scrambler_b1.sv
module fsync_scrambler_b1
    import b1s_pkg::*;
#(
    parameter int FRAME_BYTES   = 2430,
    parameter int FRAMING_BYTES = 6,
    parameter int SKIP_BYTES    = 3,
    parameter int B1_POS        = 264
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proc_en,
    input  logic [7:0] tx_byte_in,
    input  logic       tx_frame_mark,
    output logic [7:0] tx_line_out,
    input  logic [7:0] rx_line_in,
    input  logic       rx_frame_mark,
    output logic [7:0] rx_byte_out,
    output logic       b1_err_pulse
);
    logic tx_err_unused_n;

    b1s_lane #(
        .DIR          (LANE_TX),
        .FRAME_BYTES  (FRAME_BYTES),
        .FRAMING_BYTES(FRAMING_BYTES),
        .SKIP_BYTES   (SKIP_BYTES),
        .B1_POS       (B1_POS)
    ) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (proc_en),
        .din  (tx_byte_in),
        .mark (tx_frame_mark),
        .dout (tx_line_out),
        .err  (tx_err_unused_n)
    );

    b1s_lane #(
        .DIR          (LANE_RX),
        .FRAME_BYTES  (FRAME_BYTES),
        .FRAMING_BYTES(FRAMING_BYTES),
        .SKIP_BYTES   (SKIP_BYTES),
        .B1_POS       (B1_POS)
    ) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (proc_en),
        .din  (rx_line_in),
        .mark (rx_frame_mark),
        .dout (rx_byte_out),
        .err  (b1_err_pulse)
    );

    // The transmit lane never reports parity errors; its flag is folded in
    // as a constant-low term so the result is unchanged.
    logic tx_err_seen;
    assign tx_err_seen = tx_err_unused_n & 1'b0;
    logic  sink_unused;
    assign sink_unused = tx_err_seen;
endmodule

// File: rtl/b1s_checker.sv
module b1s_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       proc_en,
    input logic [7:0] tx_byte_in,
    input logic       tx_frame_mark,
    input logic [7:0] tx_line_out,
    input logic [7:0] rx_line_in,
    input logic       rx_frame_mark,
    input logic [7:0] rx_byte_out,
    input logic       b1_err_pulse
);
    logic       tx_seen_q, rx_seen_q;
    logic [3:0] err_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_seen_q <= 1'b0;
            rx_seen_q <= 1'b0;
            err_run_q <= '0;
        end else begin
            tx_seen_q <= tx_seen_q | tx_frame_mark;
            rx_seen_q <= rx_seen_q | rx_frame_mark;
            err_run_q <= b1_err_pulse ? ((err_run_q == 4'hF) ? err_run_q : err_run_q + 4'd1) : 4'd0;
        end
    end

    p_unsync_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_seen_q |=> tx_line_out == $past(tx_byte_in));
    p_unsync_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_seen_q |=> rx_byte_out == $past(rx_line_in));
    p_unsync_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_seen_q |=> !b1_err_pulse);
    p_mark_clear_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_mark |=> tx_line_out == $past(tx_byte_in));
    p_mark_clear_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_mark |=> rx_byte_out == $past(rx_line_in));
    p_pulse_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        b1_err_pulse |-> err_run_q < 4'd8);
    p_bypass_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_en |=> tx_line_out == $past(tx_byte_in));
    p_bypass_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_en |=> rx_byte_out == $past(rx_line_in));
    p_bypass_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_en |=> !b1_err_pulse);
endmodule

bind fsync_scrambler_b1 b1s_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .proc_en      (proc_en),
    .tx_byte_in   (tx_byte_in),
    .tx_frame_mark(tx_frame_mark),
    .tx_line_out  (tx_line_out),
    .rx_line_in   (rx_line_in),
    .rx_frame_mark(rx_frame_mark),
    .rx_byte_out  (rx_byte_out),
    .b1_err_pulse (b1_err_pulse)
);

// File: tb/tb_fsync_scrambler_b1.sv
module tb_fsync_scrambler_b1;
    localparam int FB   = 20;
    localparam int FRB  = 2;
    localparam int SKB  = 1;
    localparam int B1P  = 3;
    localparam int CORR = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       proc_en;
    logic [7:0] tx_byte_in, tx_line_out, rx_line_in, rx_byte_out;
    logic       tx_frame_mark, rx_frame_mark, b1_err_pulse;

    always #4 clk = ~clk;

    fsync_scrambler_b1 #(
        .FRAME_BYTES(FB), .FRAMING_BYTES(FRB), .SKIP_BYTES(SKB), .B1_POS(B1P)
    ) dut (
        .clk(clk), .rst_n(rst_n), .proc_en(proc_en),
        .tx_byte_in(tx_byte_in), .tx_frame_mark(tx_frame_mark), .tx_line_out(tx_line_out),
        .rx_line_in(rx_line_in), .rx_frame_mark(rx_frame_mark), .rx_byte_out(rx_byte_out),
        .b1_err_pulse(b1_err_pulse)
    );

    int n_run = 0;
    int n_fail = 0;

    // reference state per direction: 0 = transmit, 1 = receive
    bit         m_sync[2];
    bit         m_full[2];
    int         m_pos[2];
    logic [6:0] m_key[2];
    logic [7:0] m_acc[2];
    logic [7:0] m_b1[2];

    logic [7:0] exp_tx, exp_rx;
    string      tag_tx, tag_rx;
    int         err_left = 0;
    bit         have_exp = 0;
    bit         prev_txm = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic key_gen(input logic [6:0] s, output logic [7:0] ks, output logic [6:0] nx);
        logic [6:0] st;
        st = s;
        for (int i = 7; i >= 0; i--) begin
            ks[i] = st[6];
            st = {st[5:0], st[6] ^ st[5]};
        end
        nx = st;
    endtask

    task automatic model_step(input int d, input logic [7:0] din, input bit mk, input bit en,
                              output logic [7:0] dout, output string tag, output int errs);
        bit scr, b1p;
        logic [7:0] ks, line, pre;
        logic [6:0] nx;
        scr = m_sync[d] && !mk && m_pos[d] >= SKB && m_pos[d] < FB - FRB;
        b1p = m_sync[d] && !mk && m_pos[d] == B1P;
        key_gen(m_key[d], ks, nx);
        errs = 0;
        if (d == 0) begin
            pre  = (en && b1p) ? (m_full[d] ? m_b1[d] : 8'h00) : din;
            dout = (en && scr) ? (pre ^ ks) : pre;
            line = dout;
        end else begin
            line = din;
            dout = (en && scr) ? (din ^ ks) : din;
            if (en && b1p && m_full[d]) errs = $countones(dout ^ m_b1[d]);
        end
        if (!m_sync[d])      tag = "R1 unsynced passthrough";
        else if (!en)        tag = "R9 bypass";
        else if (!scr)       tag = "R3 framing byte clear";
        else if (d == 1)     tag = "R6 descramble";
        else if (b1p)        tag = "R5 parity insertion";
        else                 tag = "R4 scramble";
        if (mk) begin
            m_b1[d]   = m_acc[d] ^ line;
            m_acc[d]  = 8'h00;
            m_full[d] = m_sync[d];
            m_sync[d] = 1'b1;
            m_pos[d]  = 0;
            m_key[d]  = 7'h7F;
        end else begin
            m_acc[d] = m_sync[d] ? (m_acc[d] ^ line) : 8'h00;
            if (m_sync[d]) m_pos[d] = (m_pos[d] == FB - 1) ? 0 : m_pos[d] + 1;
            if (scr) m_key[d] = nx;
        end
    endtask

    task automatic step(input logic [7:0] txd, input bit txm, input logic [7:0] corrupt, input bit en);
        logic [7:0] rxd;
        int e0, e1;
        @(negedge clk);
        if (have_exp) begin
            chk(tag_tx, tx_line_out, exp_tx);
            chk(tag_rx, rx_byte_out, exp_rx);
            chk(en ? "R7 R8 error pulse train" : "R9 error quiet", {7'b0, b1_err_pulse},
                {7'b0, err_left > 0});
            if (err_left > 0) err_left--;
        end
        rxd = tx_line_out ^ corrupt;
        tx_byte_in    = txd;
        tx_frame_mark = txm;
        rx_line_in    = rxd;
        rx_frame_mark = prev_txm;
        proc_en       = en;
        model_step(0, txd, txm, en, exp_tx, tag_tx, e0);
        model_step(1, rxd, prev_txm, en, exp_rx, tag_rx, e1);
        err_left += e1;
        prev_txm = txm;
        have_exp = 1;
    endtask

    task automatic run_frame(input logic [7:0] mask, input bit en);
        for (int i = 0; i < FB; i++)
            step(8'($urandom), i == FB - 1, (i == CORR + 1) ? mask : 8'h00, en);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            m_sync[d] = 0; m_full[d] = 0; m_pos[d] = 0;
            m_key[d] = 7'h7F; m_acc[d] = 8'h00; m_b1[d] = 8'h00;
        end
        rst_n = 1'b0;
        proc_en = 1'b1;
        tx_byte_in = 8'h00; tx_frame_mark = 1'b0;
        rx_line_in = 8'h00; rx_frame_mark = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 reset tx", tx_line_out, 8'h00);
        chk("R2 reset rx", rx_byte_out, 8'h00);
        chk("R2 reset err", {7'b0, b1_err_pulse}, 8'h00);
        rst_n = 1'b1;
        // R1: bytes before any marker
        for (int k = 0; k < 6; k++) step(8'($urandom), 1'b0, 8'h00, 1'b1);
        // R4 R5 R6 R7 R8: every corruption mask exercised against the parity check
        for (int f = 0; f < 258; f++) run_frame(8'(f), 1'b1);
        // R9: bypass with corrupted line data
        for (int f = 0; f < 4; f++) run_frame(8'hFF, 1'b0);
        // back to active, across the bypass boundary
        for (int f = 0; f < 4; f++) run_frame(8'h3C, 1'b1);
        run_frame(8'h00, 1'b1);
        step(8'h00, 1'b0, 8'h00, 1'b1);
        summary();
        $finish;
    end
endmodule